// File: doc/BRIEF.md
# Selective Snapshot-Clear Status Register

This block is an 8-bit event status register that sits behind a simple synchronous host register port. Some bit positions are latched event flags and the rest are live condition bits. A latched flag is set by a one-cycle event pulse. It stays set until the host asks for it.

The host retrieves a flag by writing a select mask to the status register. For every position selected with a 1, the block copies the current latch value into a held snapshot and clears the latch. Positions written as 0 keep their earlier snapshot and their latch. The host then reads the snapshot. To catch an event that arrived between the snapshot and the clear, the host writes the value it read, ANDed with its mask, a second time. A mask register decides which latched flags drive the active-low interrupt.

Top module: `sscs_status`

## Requirements
- R1: A latched bit (positions 5..0 with the default `LATCHED = 8'h3F`) goes to 1 on the cycle after its `evt_i` pulse and stays 1 until a status write selects it.
- R2: A latched bit that has been cleared reads 0 in every later snapshot until its event pulses again.
- R3: Real-time bits (positions 7..6 by default) always read the present `cond_i` value on `bus_rdata` while `bus_sel` = 0. Status writes have no effect on them.
- R4: A write with `bus_sel` = 0 and `bus_wdata[i]` = 1 loads the snapshot bit i with the latch value (OR the same-cycle event) and clears latch i. The new snapshot is readable on `bus_rdata` after that clock edge.
- R5: A status write with `bus_wdata[i]` = 0 leaves snapshot bit i and latch i unchanged.
- R6: A write with `bus_sel` = 1 loads the interrupt mask. Reading with `bus_sel` = 1 returns it. A mask bit of 1 enables the matching latched flag onto the interrupt.
- R7: `irq_n` goes low one clock after a latched flag with an enabled mask bit becomes 1.
- R8: `irq_n` returns high one clock after the last enabled pending flag is cleared by a selecting status write.
- R9: If an event pulse and a clear-select for the same bit fall in the same cycle, the snapshot captures 1 and the latch stays 1.
- R10: A second status write of the read value ANDed with the mask clears a bit that was set again after the first snapshot. It leaves unselected bits untouched.
- R11: After reset all latches, snapshots and mask bits are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | One-cycle event pulses for latched positions |
| cond_i | input | 8 | Live conditions for real-time positions |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 status, 1 interrupt mask |
| bus_wdata | input | 8 | Write data (select mask or mask value) |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is an event pulse that lands in exactly the cycle of a clear-select for the same bit, and a re-set that lands between a snapshot write and the follow-up clearing write. The bench drives event pulses and bus writes in the same cycle from one task. This lets it place an event on, before or after a select write. It also sweeps all 64 patterns of the latched field through the mask, event and select inputs, and compares snapshot, mask and interrupt against a model of the requirements.

// File: rtl/sscs_pkg.sv
package sscs_pkg;
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic lat;
        logic snap;
    } bit_state_t;
endpackage

// File: rtl/sscs_bit.sv
module sscs_bit #(
    parameter bit IS_LATCHED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic cond,
    input  logic clr_sel,
    output logic lat_q,
    output logic snap_q,
    output logic view
);
    import sscs_pkg::*;

    generate
        if (IS_LATCHED) begin : g_lat
            bit_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (clr_sel) begin
                    st_d.snap = st_q.lat | evt;
                    st_d.lat  = evt;
                end else begin
                    st_d.lat  = st_q.lat | evt;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign lat_q  = st_q.lat;
            assign snap_q = st_q.snap;
            assign view   = st_q.snap;
        end else begin : g_live
            assign lat_q  = 1'b0;
            assign snap_q = 1'b0;
            assign view   = cond;
        end
    endgenerate
endmodule

// File: rtl/sscs_irq.sv
module sscs_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lat,
    input  logic [W-1:0] enable,
    output logic         irq_n
);
    typedef struct packed {
        logic irq_n;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~|(lat & enable);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{irq_n: 1'b1};
        else        st_q <= st_d;
    end

    assign irq_n = st_q.irq_n;
endmodule

// File: rtl/sscs_status.sv
module sscs_status #(
    parameter int          W       = 8,
    parameter logic [W-1:0] LATCHED = 8'h3F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] cond_i,
    input  logic         bus_wr,
    input  logic         bus_sel,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_n
);
    import sscs_pkg::*;

    typedef struct packed {
        logic [W-1:0] mask;
    } top_state_t;

    top_state_t   st_d, st_q;
    logic [W-1:0] clr_sel;
    logic [W-1:0] lat_vec;
    logic [W-1:0] snap_vec;
    logic [W-1:0] view_vec;
    logic [W-1:0] mask_q;

    always_comb begin
        st_d    = st_q;
        clr_sel = '0;
        if (bus_wr) begin
            if (reg_sel_e'(bus_sel) == SEL_MASK) st_d.mask = bus_wdata;
            else                                 clr_sel   = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;

    for (genvar i = 0; i < W; i++) begin : g_bit
        sscs_bit #(.IS_LATCHED(LATCHED[i])) u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_i[i]),
            .cond    (cond_i[i]),
            .clr_sel (clr_sel[i]),
            .lat_q   (lat_vec[i]),
            .snap_q  (snap_vec[i]),
            .view    (view_vec[i])
        );
    end

    sscs_irq #(.W(W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .lat    (lat_vec),
        .enable (mask_q & LATCHED),
        .irq_n  (irq_n)
    );

    assign bus_rdata = (reg_sel_e'(bus_sel) == SEL_MASK) ? mask_q : view_vec;
endmodule

// File: rtl/sscs_status_chk.sv
module sscs_status_chk #(
    parameter int          W       = 8,
    parameter logic [W-1:0] LATCHED = 8'h3F
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_i,
    input logic         bus_wr,
    input logic         bus_sel,
    input logic [W-1:0] bus_wdata,
    input logic         irq_n,
    input logic [W-1:0] lat_vec,
    input logic [W-1:0] snap_vec,
    input logic [W-1:0] mask_q
);
    for (genvar i = 0; i < W; i++) begin : g_chk
        if (LATCHED[i]) begin : g_l
            a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> lat_vec[i]);
            a_r1_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (lat_vec[i] && !(bus_wr && !bus_sel && bus_wdata[i])) |=> lat_vec[i]);
            a_r2_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (!lat_vec[i] && !evt_i[i]) |=> !lat_vec[i]);
            a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && !bus_sel && bus_wdata[i]) |=> (snap_vec[i] == ($past(lat_vec[i]) | $past(evt_i[i]))));
            a_r5_snap_held: assert property (@(posedge clk) disable iff (!rst_n)
                !(bus_wr && !bus_sel && bus_wdata[i]) |=> $stable(snap_vec[i]));
            a_r9_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && !bus_sel && bus_wdata[i] && evt_i[i]) |=> (lat_vec[i] && snap_vec[i]));
        end
    end

    a_r7_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == !(|($past(lat_vec) & $past(mask_q) & LATCHED))));
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel) |=> (mask_q == $past(bus_wdata)));
endmodule

bind sscs_status sscs_status_chk #(.W(W), .LATCHED(LATCHED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .lat_vec   (lat_vec),
    .snap_vec  (snap_vec),
    .mask_q    (mask_q)
);

// File: tb/sim_sscs_status.sv
`timescale 1ns/1ps
module sim_sscs_status;
    localparam logic [7:0] L = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0, cond_i = '0, bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int total = 0, bad = 0;
    logic [7:0] m_lat = '0, m_snap = '0, m_mask = '0;
    logic       m_irq = 1'b1;

    always #5 clk = ~clk;

    sscs_status u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cond_i(cond_i),
        .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, model update at posedge, check status view and irq
    task automatic cyc(input string req, input logic [7:0] ev, input logic wr,
                       input logic sel, input logic [7:0] wd);
        logic [7:0] cs;
        @(negedge clk);
        evt_i = ev; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
        @(posedge clk);
        cs     = (wr && !sel) ? (wd & L) : 8'h00;
        m_irq  = ~|(m_lat & m_mask & L);
        m_snap = (m_snap & ~cs) | ((m_lat | ev) & cs & L);
        m_lat  = ((m_lat & ~cs) | ev) & L;
        if (wr && sel) m_mask = wd;
        #1;
        evt_i = '0; bus_wr = 1'b0; bus_sel = 1'b0;
        #1;
        chk8(req, bus_rdata, (m_snap & L) | (cond_i & ~L));
        chk8(req, {7'd0, irq_n}, {7'd0, m_irq});
    endtask

    task automatic chk_mask(input string req);
        @(negedge clk);
        bus_sel = 1'b1;
        #1;
        chk8(req, bus_rdata, m_mask);
        bus_sel = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R11 reset state
        chk8("R11", bus_rdata, 8'h00);
        chk8("R11", {7'd0, irq_n}, 8'h01);
        chk_mask("R11");

        // R1 set and hold, snapshot not yet taken
        cyc("R1", 8'h05, 0, 0, 0);
        cyc("R1", 8'h00, 0, 0, 0);
        cyc("R4", 8'h00, 1, 0, 8'h01);        // snapshot bit0 only
        cyc("R5", 8'h00, 1, 0, 8'h00);        // nothing selected: hold
        cyc("R1", 8'h00, 1, 0, 8'h04);        // bit2 still latched
        cyc("R2", 8'h00, 1, 0, 8'h05);        // both cleared now
        // R3 live bits ignore writes
        cond_i = 8'hC0;
        cyc("R3", 8'h00, 1, 0, 8'hFF);
        cond_i = 8'h40;
        cyc("R3", 8'h00, 1, 0, 8'hC0);
        cond_i = 8'h00;
        // R6 mask load and readback
        cyc("R6", 8'h00, 1, 1, 8'h12);
        chk_mask("R6");
        // R7 interrupt after enabled event
        cyc("R7", 8'h10, 0, 0, 0);
        cyc("R7", 8'h00, 0, 0, 0);
        chk8("R7", {7'd0, irq_n}, 8'h00);
        // disabled event leaves irq as is, enabled one still pending
        cyc("R6", 8'h01, 0, 0, 0);
        cyc("R8", 8'h00, 1, 0, 8'h10);
        cyc("R8", 8'h00, 0, 0, 0);
        chk8("R8", {7'd0, irq_n}, 8'h01);
        cyc("R2", 8'h00, 1, 0, 8'h01);
        // R9 event coincides with clear-select
        cyc("R9", 8'h02, 0, 0, 0);
        cyc("R9", 8'h02, 1, 0, 8'h02);
        cyc("R9", 8'h00, 1, 0, 8'h02);
        cyc("R2", 8'h00, 1, 0, 8'h02);
        // R10 write-read-write with re-set in between
        cyc("R10", 8'h28, 0, 0, 0);
        cyc("R10", 8'h00, 1, 0, 8'h28);       // snapshot both
        cyc("R10", 8'h08, 0, 0, 0);           // bit3 set again
        cyc("R10", 8'h01, 0, 0, 0);           // unrelated bit0
        cyc("R10", 8'h00, 1, 0, bus_rdata & 8'h28);
        cyc("R10", 8'h00, 1, 0, 8'h29);       // bit3 was cleared, bit0 kept

        // sweep over the latched field
        for (int p = 0; p < 64; p++) begin
            logic [7:0] pv;
            pv = p[7:0];
            cyc("R6", 8'h00, 1, 1, pv ^ 8'h15);
            cyc("R1", pv, 0, 0, 0);
            cyc("R7", (pv >> 1) & L, 1, 0, (pv ^ 8'h2A) & L);
            cyc("R9", pv & 8'h0C, 1, 0, pv & L);
            cyc("R5", 8'h00, 1, 0, ~pv & L);
            cyc("R8", 8'h00, 1, 0, L);
            cyc("R8", 8'h00, 0, 0, 0);
        end
        chk_mask("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule